// File: doc/BRIEF.md
# Queued SPI Slave Engine

This block is an SPI slave that works through a queue of transfer entries stored in local RAM, rather than through one fixed shift register. Every entry has its own bit count, a transmit word and a receive word. While slave select is low, the engine shifts one bit on each rising SCK edge, most significant bit first. When an entry's bit count is reached, the engine stores the received word, records which entry just finished, and moves its working pointer on to the next entry.

A host register port loads the transmit words and bit counts, reads back the received words, and programs the control fields. These are the enable, the interrupt enable, the wrap enable, the wrap target, the new-queue pointer and the end-of-queue pointer. When the engine finishes the entry at the end pointer, it sets a sticky completion flag. It then either stops and clears its own enable, or wraps to entry 0 or to the new-queue pointer. SCK, slave select and MOSI are synchronized into the system clock domain, so SCK must run well below the system clock.

The controller has four states:
- S_OFF (idle). It moves to S_ARM when the enable is set.
- S_ARM (waiting for select). It goes back to S_OFF when the enable is clear. It moves to S_LOAD when select is low.
- S_LOAD (one cycle). It loads the entry into the serializer and moves to S_SHIFT.
- S_SHIFT. It goes to S_ARM on deselect. On entry completion it goes to S_ARM, or to S_OFF at the end of the queue when wrap is off. It also goes to S_OFF if the host clears the enable.

Top module: `qspi_slave_queue`

## Requirements
- R1: While enabled and selected, each rising SCK edge shifts in one MOSI bit. MISO presents the entry's transmit word MSB first, starting with bit n-1. After n edges, the receive word for that entry holds the n received bits right-justified, and its upper bits are zero.
- R2: Each entry's bit count is a 4-bit field, at host address 0x20+i. Values 1 to 15 give that many bits, and 0 means 16 bits. Transmit words are at 0x00+i, and receive words are read at 0x10+i.
- R3: When an entry completes, the completed-pointer field (status register 0x33, bits [3:0]) takes the working pointer's value, and the working pointer moves to the next entry.
- R4: If select rises before the bit count is reached, neither pointer changes and the receive word is not written. The next select restarts the same entry from its first transmit bit.
- R5: If select stays low across an entry boundary, transfer continues with the next entry.
- R6: A host write of the new-queue pointer (0x31) makes the next entry start at that address instead of at the working pointer.
- R7: Completing the entry whose index equals the end pointer (0x32) sets the completion flag (status bit 4). The flag stays set until the host writes 1 to status bit 4. The irq output is the flag gated by the interrupt enable (control 0x30, bit 1).
- R8: At the end of the queue with wrap off (control bit 2 = 0), the engine clears its enable (control bit 0) and stops.
- R9: At the end of the queue with wrap on, the engine stays enabled and continues from entry 0 when control bit 3 is 0, or from the new-queue pointer when control bit 3 is 1.
- R10: After reset, all registers read 0, and irq and MISO are low. While the engine is disabled, SCK edges change no receive word and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host address: [5:4] space, [3:0] index/register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench targets these corner cases:
- An early deselect part way through an entry. A design that advanced or saved partial state would shift the pointers, or would restart mid-word on the next select, and the MISO bits would come out wrong.
- A bit count of zero. A design that treated it as zero bits, rather than as 16, would complete the entry immediately.
- Select held low across entry boundaries. A design that needed a select edge between entries would stall.
- Both wrap targets, and a back-to-back wrap onto the end entry itself. These expose a design that ignored the target bit or failed to keep its enable set.
- The disabled state. A design that kept shifting while disabled would overwrite receive words.

// File: rtl/qse_pkg.sv
package qse_pkg;
    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_ARM   = 2'd1,
        S_LOAD  = 2'd2,
        S_SHIFT = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        SP_TX  = 2'b00,
        SP_RX  = 2'b01,
        SP_BC  = 2'b10,
        SP_REG = 2'b11
    } host_space_t;

    localparam logic [1:0] RG_CTRL  = 2'd0;
    localparam logic [1:0] RG_NEWQP = 2'd1;
    localparam logic [1:0] RG_ENDQP = 2'd2;
    localparam logic [1:0] RG_STAT  = 2'd3;
endpackage

// File: rtl/qse_sync.sv
module qse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ss_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sel,
    output logic mosi_s
);
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] ss_q;
    logic [STAGES-1:0] mo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            ss_q  <= '1;
            mo_q  <= '0;
        end else begin
            sck_q <= {sck_q[STAGES-1:0], sck};
            ss_q  <= {ss_q[STAGES-2:0], ss_n};
            mo_q  <= {mo_q[STAGES-2:0], mosi};
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sel      = ~ss_q[STAGES-1];
    assign mosi_s   = mo_q[STAGES-1];
endmodule

// File: rtl/qse_ram.sv
module qse_ram #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  host_idx,
    input  logic              host_we_tx,
    input  logic              host_we_bc,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_tx,
    output logic [DATA_W-1:0] host_rx,
    output logic [CNT_W-1:0]  host_bc,
    input  logic [PTR_W-1:0]  eng_idx,
    input  logic              eng_rx_we,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic [DATA_W-1:0] eng_tx,
    output logic [CNT_W-1:0]  eng_bc
);
    logic [DATA_W-1:0] tx_mem [DEPTH];
    logic [DATA_W-1:0] rx_mem [DEPTH];
    logic [CNT_W-1:0]  bc_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tx_mem[i] <= '0;
                rx_mem[i] <= '0;
                bc_mem[i] <= '0;
            end
        end else begin
            if (host_we_tx) tx_mem[host_idx] <= host_wdata;
            if (host_we_bc) bc_mem[host_idx] <= host_wdata[CNT_W-1:0];
            if (eng_rx_we)  rx_mem[eng_idx]  <= eng_rx_data;
        end
    end

    assign host_tx = tx_mem[host_idx];
    assign host_rx = rx_mem[host_idx];
    assign host_bc = bc_mem[host_idx];
    assign eng_tx  = tx_mem[eng_idx];
    assign eng_bc  = bc_mem[eng_idx];
endmodule

// File: rtl/qspi_slave_queue.sv
module qspi_slave_queue
    import qse_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int AW    = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int LEN_W = CNT_W + 1;

    eng_state_t        state, nxt;
    logic              sck_rise, sel, mosi_s;
    logic [PTR_W-1:0]  wptr, cptr, newqp, endqp;
    logic              newqp_pend, en, ie, wrap_en, wrap_to, flag;
    logic [DATA_W-1:0] shreg, shifted;
    logic [LEN_W-1:0]  cnt, len;
    logic [DATA_W-1:0] eng_tx, host_tx, host_rx;
    logic [CNT_W-1:0]  eng_bc, host_bc;
    logic              done_ev, at_end, consume;
    host_space_t       space;
    logic [1:0]        reg_sel;
    logic              wr_ctrl, wr_newqp, wr_endqp, wr_stat;

    qse_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .sck_rise(sck_rise), .sel(sel), .mosi_s(mosi_s)
    );

    assign space    = host_space_t'(host_addr[AW-1 -: 2]);
    assign reg_sel  = host_addr[1:0];
    assign wr_ctrl  = host_we && space == SP_REG && reg_sel == RG_CTRL;
    assign wr_newqp = host_we && space == SP_REG && reg_sel == RG_NEWQP;
    assign wr_endqp = host_we && space == SP_REG && reg_sel == RG_ENDQP;
    assign wr_stat  = host_we && space == SP_REG && reg_sel == RG_STAT;

    assign len     = (eng_bc == '0) ? LEN_W'(DATA_W) : {1'b0, eng_bc};
    assign shifted = {shreg[DATA_W-2:0], mosi_s};
    assign done_ev = (state == S_SHIFT) && sel && sck_rise && (cnt + 1'b1 == len);
    assign at_end  = (wptr == endqp);
    assign consume = (state == S_ARM) && en && sel;

    qse_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .host_idx(host_addr[PTR_W-1:0]),
        .host_we_tx(host_we && space == SP_TX),
        .host_we_bc(host_we && space == SP_BC),
        .host_wdata(host_wdata),
        .host_tx(host_tx), .host_rx(host_rx), .host_bc(host_bc),
        .eng_idx(wptr), .eng_rx_we(done_ev), .eng_rx_data(shifted),
        .eng_tx(eng_tx), .eng_bc(eng_bc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (en) nxt = S_ARM;
            S_ARM:   if (!en) nxt = S_OFF;
                     else if (sel) nxt = S_LOAD;
            S_LOAD:  nxt = S_SHIFT;
            S_SHIFT: if (!sel) nxt = S_ARM;
                     else if (done_ev) nxt = (at_end && !wrap_en) ? S_OFF : S_ARM;
                     else if (!en) nxt = S_OFF;
            default: nxt = S_OFF;
        endcase
    end

    // Datapath and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; cnt <= '0; wptr <= '0; cptr <= '0;
            newqp <= '0; endqp <= '0; newqp_pend <= 1'b0;
            en <= 1'b0; ie <= 1'b0; wrap_en <= 1'b0; wrap_to <= 1'b0; flag <= 1'b0;
        end else begin
            if (state == S_LOAD) begin
                shreg <= eng_tx << (LEN_W'(DATA_W) - len);
                cnt   <= '0;
            end else if (state == S_SHIFT && sel && sck_rise) begin
                shreg <= shifted;
                cnt   <= cnt + 1'b1;
            end

            if (consume && newqp_pend) wptr <= newqp;
            else if (done_ev) begin
                if (!at_end)      wptr <= wptr + 1'b1;
                else if (wrap_en) wptr <= wrap_to ? newqp : '0;
            end
            if (done_ev) cptr <= wptr;

            if (wr_newqp) begin
                newqp      <= host_wdata[PTR_W-1:0];
                newqp_pend <= 1'b1;
            end else if (consume) begin
                newqp_pend <= 1'b0;
            end
            if (wr_endqp) endqp <= host_wdata[PTR_W-1:0];

            if (wr_ctrl) begin
                en      <= host_wdata[0];
                ie      <= host_wdata[1];
                wrap_en <= host_wdata[2];
                wrap_to <= host_wdata[3];
            end else if (done_ev && at_end && !wrap_en) begin
                en <= 1'b0;
            end

            if (done_ev && at_end)                 flag <= 1'b1;
            else if (wr_stat && host_wdata[PTR_W]) flag <= 1'b0;
        end
    end

    assign miso = shreg[DATA_W-1];
    assign irq  = flag & ie;

    always_comb begin
        host_rdata = '0;
        unique case (space)
            SP_TX:  host_rdata = host_tx;
            SP_RX:  host_rdata = host_rx;
            SP_BC:  host_rdata[CNT_W-1:0] = host_bc;
            SP_REG: begin
                unique case (reg_sel)
                    RG_CTRL:  host_rdata[3:0] = {wrap_to, wrap_en, ie, en};
                    RG_NEWQP: host_rdata[PTR_W-1:0] = newqp;
                    RG_ENDQP: host_rdata[PTR_W-1:0] = endqp;
                    RG_STAT:  host_rdata[PTR_W:0] = {flag, cptr};
                    default:  host_rdata = '0;
                endcase
            end
            default: host_rdata = '0;
        endcase
    end

    // R1: the serializer only moves on a detected SCK edge
    a_r1_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && !sck_rise) |=> $stable(shreg));

    // R3: completed pointer captures the working pointer of the finished entry
    a_r3_cptr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        done_ev |=> (cptr == $past(wptr)));

    // R4: deselect during an entry leaves the working pointer alone
    a_r4_keep_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT && !sel) |=> $stable(wptr));

    // R7: the flag only rises after finishing the end entry
    a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(state == S_SHIFT && at_end));

    // R8: end of queue without wrap stops the engine
    a_r8_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && at_end && !wrap_en && !wr_ctrl) |=> (!en && state == S_OFF));

    // R9: wrap to zero
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && at_end && wrap_en && !wrap_to) |=> (wptr == '0 && en));
endmodule

// File: tb/tb_qspi_slave_queue.sv
module tb_qspi_slave_queue;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        ss_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qspi_slave_queue dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    // {bit count code, transmit word, MOSI word}
    localparam logic [35:0] VEC [6] = '{
        {4'd8,  16'h00A5, 16'h003C},
        {4'd0,  16'hBEEF, 16'h1234},
        {4'd1,  16'h0001, 16'h0001},
        {4'd4,  16'h0009, 16'h0006},
        {4'd12, 16'h0ABC, 16'h0321},
        {4'd15, 16'h7FFE, 16'h4001}
    };

    function automatic int nbits(input logic [3:0] code);
        return (code == 4'd0) ? 16 : int'(code);
    endfunction

    function automatic logic [15:0] lowmask(input int n);
        return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic select(input logic low);
        @(negedge clk);
        ss_n = ~low;
        if (!low) repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input int n, input logic [15:0] mo, output logic [15:0] mi);
        mi = '0;
        for (int b = n - 1; b >= 0; b--) begin
            @(negedge clk);
            mosi = mo[b];
            repeat (HALF) @(negedge clk);
            mi = {mi[14:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] d, mi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 miso after reset", {15'd0, miso}, 16'h0);
        chk("R10 irq after reset", {15'd0, irq}, 16'h0);
        rd(6'h30, d); chk("R10 ctrl after reset", d, 16'h0);
        rd(6'h33, d); chk("R10 status after reset", d, 16'h0);

        for (int i = 0; i < 6; i++) begin
            wr(6'h00 + 6'(i), VEC[i][31:16]);
            wr(6'h20 + 6'(i), {12'd0, VEC[i][35:32]});
        end
        wr(6'h32, 16'd5);
        wr(6'h30, 16'h0003);

        // Table walk: R1, R2, R3 per entry, select toggled between entries
        for (int i = 0; i < 6; i++) begin
            int n;
            n = nbits(VEC[i][35:32]);
            select(1'b1);
            xfer(n, VEC[i][15:0], mi);
            select(1'b0);
            chk($sformatf("R1 miso bits entry %0d", i), mi, VEC[i][31:16] & lowmask(n));
            rd(6'h10 + 6'(i), d);
            chk($sformatf("R2 rx word entry %0d", i), d, VEC[i][15:0] & lowmask(n));
            rd(6'h33, d);
            chk($sformatf("R3 completed ptr entry %0d", i), d & 16'h000F, 16'(i));
        end
        rd(6'h33, d); chk("R7 flag set at end", d & 16'h0010, 16'h0010);
        chk("R7 irq with enable", {15'd0, irq}, 16'h1);
        rd(6'h30, d); chk("R8 enable cleared at end", d & 16'h0001, 16'h0);

        // R7 clear, R6 new pointer, R4 early deselect, R5 continuous select
        wr(6'h33, 16'h0010);
        chk("R7 irq after clear", {15'd0, irq}, 16'h0);
        wr(6'h31, 16'd4);
        wr(6'h30, 16'h0003);
        select(1'b1);
        xfer(5, 16'h001F, mi);
        select(1'b0);
        rd(6'h33, d); chk("R4 ptr kept on early deselect", d & 16'h000F, 16'd5);
        rd(6'h14, d); chk("R4 rx untouched on early deselect", d, 16'h0321);
        select(1'b1);
        xfer(12, 16'h0F0F, mi);
        chk("R4 restart from first bit", mi, 16'h0ABC);
        rd(6'h14, d); chk("R6 entry from new pointer", d, 16'h0F0F);
        xfer(15, 16'h2AAA, mi);
        chk("R5 next entry miso", mi, 16'h7FFE);
        select(1'b0);
        rd(6'h15, d); chk("R5 next entry rx", d, 16'h2AAA);
        rd(6'h33, d); chk("R5 status after end", d, 16'h0015);

        // R9 wrap to entry 0, interrupt disabled
        wr(6'h33, 16'h0010);
        wr(6'h31, 16'd5);
        wr(6'h30, 16'h0005);
        select(1'b1);
        xfer(15, 16'h1111, mi);
        select(1'b0);
        rd(6'h33, d); chk("R7 flag with irq disabled", d & 16'h0010, 16'h0010);
        chk("R7 irq gated off", {15'd0, irq}, 16'h0);
        rd(6'h30, d); chk("R9 enable kept on wrap", d & 16'h0001, 16'h1);
        select(1'b1);
        xfer(8, 16'h005A, mi);
        select(1'b0);
        rd(6'h10, d); chk("R9 wrapped to entry 0", d, 16'h005A);
        rd(6'h33, d); chk("R9 completed ptr 0", d & 16'h000F, 16'h0);

        // R9 wrap to the new-queue pointer
        wr(6'h30, 16'h000D);
        wr(6'h31, 16'd5);
        select(1'b1);
        xfer(15, 16'h0123, mi);
        xfer(15, 16'h7654, mi);
        select(1'b0);
        rd(6'h15, d); chk("R9 wrapped to new pointer", d, 16'h7654);
        rd(6'h33, d); chk("R9 completed ptr 5", d & 16'h000F, 16'd5);

        // R10 disabled engine ignores SCK
        wr(6'h30, 16'h0000);
        repeat (4) @(negedge clk);
        select(1'b1);
        xfer(8, 16'h00FF, mi);
        select(1'b0);
        rd(6'h10, d); chk("R10 rx0 unchanged when disabled", d, 16'h005A);
        rd(6'h15, d); chk("R10 rx5 unchanged when disabled", d, 16'h7654);
        rd(6'h33, d); chk("R10 ptr unchanged when disabled", d & 16'h000F, 16'd5);

        summary();
    end
endmodule